// File: doc/BRIEF.md
# Receive Stream Framing Checker

This block sits on the receive-direction application stream that delivers packets to a DMA engine. It monitors every beat that completes a valid/ready handshake. Each beat carries data, first and last flags, an error flag, an even-parity bit and a byte count. Each packet also comes with a metadata length. The checker passes the beats through untouched. It keeps track of whether a packet is open and accumulates received bytes in a saturating counter. It reports protocol violations as single-cycle pulses on a 32-bit error-cause vector, whose bit positions a downstream cause register decodes.

The byte counter is `CNT_W` bits wide (32 by default) and never wraps. Data arriving without framing flags keeps adding to the counter until it sticks at all ones. The first cycle at that value produces a saturation pulse. Length checking uses the count that includes the beat carrying last, compared with the metadata length presented on that beat.

Top module: `rx_frame_checker`

## Requirements
- R1: The beat is forwarded combinationally and unchanged: `out_valid`, `out_data`, `out_first`, `out_last` and `out_bytes` equal the corresponding inputs, and `in_ready` equals `out_ready`, in every cycle.
- R2: `err_cause` is registered. It reads zero during and right after reset. In each cycle it shows the causes produced by the beat accepted at the previous clock edge, and zero if no beat was accepted at that edge.
- R3: An accepted beat with last set, first clear and no packet open sets bit 23 of `err_cause`, and it is not length-checked.
- R4: An accepted beat with first set while a packet is open sets bit 22. That beat starts a new packet, and the count restarts from its byte count.
- R5: On an accepted beat with last set that closes a packet (either a packet is open, or first is set on the same beat), bit 24 is set when the byte count including that beat differs from `in_meta_len`. After such a beat no packet is open.
- R6: An accepted beat with `in_err` high sets bit 21.
- R7: Parity is even: an accepted beat for which the XOR of all `in_data` bits and `in_par` is 1 sets bit 20.
- R8: Every accepted beat without first adds its byte count to the counter, whether or not a packet is open. The sum saturates at all ones. Bit 12 pulses only on the beat that takes the counter to all ones from a lower value. A beat with first reloads the counter.
- R9: A beat without a completed handshake (`in_valid` low or `out_ready` low) sets no cause bit and changes neither the open state nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream ready (copy of `out_ready`) |
| in_data | input | DATA_W | Beat data |
| in_first | input | 1 | First beat of a packet |
| in_last | input | 1 | Last beat of a packet |
| in_err | input | 1 | Upstream error flag on this beat |
| in_par | input | 1 | Even-parity bit over `in_data` |
| in_bytes | input | BYTES_W | Valid bytes in this beat |
| in_meta_len | input | CNT_W | Metadata packet length, checked on the closing beat |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Forwarded data |
| out_first | output | 1 | Forwarded first flag |
| out_last | output | 1 | Forwarded last flag |
| out_bytes | output | BYTES_W | Forwarded byte count |
| err_cause | output | 32 | Cause pulses: 24 length, 23 stray last, 22 early first, 21 beat error, 20 parity, 12 saturation |

## Verification
The bench probes several cases: a single-beat packet with first and last together, a first that arrives inside an open packet, a last with nothing open, and stall cycles that carry bad flags and bad parity. A design that mishandled these would miss the length check on single-beat packets or check a stray last against the metadata. It could also fail to restart the count on an early first, or react to beats that were never accepted. The bench uses a narrow counter to drive the count to all ones, both exactly and by overshooting, and then keeps adding. A wrapping counter would show a small count and a length mismatch. A level-style saturation flag would pulse again on every following beat.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;
    localparam int CAUSE_W      = 32;
    localparam int BIT_LEN_ERR  = 24;
    localparam int BIT_LAST_ERR = 23;
    localparam int BIT_FIRST_ERR= 22;
    localparam int BIT_BEAT_ERR = 21;
    localparam int BIT_PAR_ERR  = 20;
    localparam int BIT_SAT_ERR  = 12;

    typedef struct packed {
        logic open;
    } frame_state_t;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } cause_state_t;
endpackage

// File: rtl/rx_even_parity.sv
module rx_even_parity #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              par_err
);
    localparam int LANES = (DATA_W + 7) / 8;
    localparam int PAD_W = LANES * 8;

    logic [PAD_W-1:0] padded;
    logic [LANES-1:0] lane_x;

    always_comb begin
        padded = '0;
        padded[DATA_W-1:0] = data;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_x[g] = ^padded[g*8 +: 8];
    end

    assign par_err = (^lane_x) ^ par;
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               first,
    input  logic [BYTES_W-1:0] bytes,
    output logic [CNT_W-1:0]   cnt_incl,
    output logic               sat_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int               SUM_W   = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        sum      = {1'b0, st_q.cnt} + {{(SUM_W-BYTES_W){1'b0}}, bytes};
        sat_hit  = 1'b0;
        if (fire) begin
            if (first) begin
                st_d.cnt = {{(CNT_W-BYTES_W){1'b0}}, bytes};
            end else begin
                st_d.cnt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
                sat_hit  = (st_d.cnt == CNT_MAX) && (st_q.cnt != CNT_MAX);
            end
        end
        cnt_incl = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !(fire && first)) |=> (st_q.cnt == CNT_MAX));

    // R8
    sat_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hit |=> !sat_hit);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(st_q.cnt));
endmodule

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker
    import rx_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic first,
    input  logic last,
    output logic first_err,
    output logic last_err,
    output logic len_chk
);
    frame_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        first_err = 1'b0;
        last_err  = 1'b0;
        len_chk   = 1'b0;
        if (fire) begin
            first_err = first && st_q.open;
            if (last) begin
                if (first || st_q.open) len_chk  = 1'b1;
                else                    last_err = 1'b1;
                st_d.open = 1'b0;
            end else if (first) begin
                st_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last) |=> !st_q.open);

    // R4
    first_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && first && !last) |=> st_q.open);

    // R3
    stray_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_err |-> !st_q.open);
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
    import rx_frame_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BYTES_W = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_first,
    input  logic               in_last,
    input  logic               in_err,
    input  logic               in_par,
    input  logic [BYTES_W-1:0] in_bytes,
    input  logic [CNT_W-1:0]   in_meta_len,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_first,
    output logic               out_last,
    output logic [BYTES_W-1:0] out_bytes,
    output logic [CAUSE_W-1:0] err_cause
);
    logic             fire;
    logic             par_err, first_err, last_err, len_chk, sat_hit;
    logic [CNT_W-1:0] cnt_incl;
    cause_state_t     cs_d, cs_q;

    assign fire      = in_valid && out_ready;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
    assign out_first = in_first;
    assign out_last  = in_last;
    assign out_bytes = in_bytes;

    rx_even_parity #(.DATA_W(DATA_W)) u_par (
        .data    (in_data),
        .par     (in_par),
        .par_err (par_err)
    );

    rx_frame_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .first     (in_first),
        .last      (in_last),
        .first_err (first_err),
        .last_err  (last_err),
        .len_chk   (len_chk)
    );

    rx_len_counter #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .first    (in_first),
        .bytes    (in_bytes),
        .cnt_incl (cnt_incl),
        .sat_hit  (sat_hit)
    );

    always_comb begin
        cs_d.cause = '0;
        if (fire) begin
            cs_d.cause[BIT_LEN_ERR]   = len_chk && (cnt_incl != in_meta_len);
            cs_d.cause[BIT_LAST_ERR]  = last_err;
            cs_d.cause[BIT_FIRST_ERR] = first_err;
            cs_d.cause[BIT_BEAT_ERR]  = in_err;
            cs_d.cause[BIT_PAR_ERR]   = par_err;
            cs_d.cause[BIT_SAT_ERR]   = sat_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign err_cause = cs_q.cause;

    // R2
    cause_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs_q.cause) |-> $past(fire));

    // R9
    no_fire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (cs_q.cause == '0));

    // R3
    last_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.cause[BIT_LAST_ERR] |-> !cs_q.cause[BIT_LEN_ERR] && !cs_q.cause[BIT_FIRST_ERR]);
endmodule

// File: tb/test_rx_frame_checker.sv
module test_rx_frame_checker;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 32;
    localparam int BYTES_W = 8;
    localparam int CNT_W   = 12;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_ready, in_first = 0, in_last = 0, in_err = 0, in_par = 0;
    logic [DATA_W-1:0]  in_data = '0;
    logic [BYTES_W-1:0] in_bytes = '0;
    logic [CNT_W-1:0]   in_meta_len = '0;
    logic out_valid, out_ready = 0, out_first, out_last;
    logic [DATA_W-1:0]  out_data;
    logic [BYTES_W-1:0] out_bytes;
    logic [31:0]        err_cause;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference state
    bit     m_open = 0;
    longint m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_checker #(.DATA_W(DATA_W), .BYTES_W(BYTES_W), .CNT_W(CNT_W)) i_rx_frame_checker (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_err(in_err), .in_par(in_par),
        .in_bytes(in_bytes), .in_meta_len(in_meta_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .out_bytes(out_bytes),
        .err_cause(err_cause)
    );

    function automatic string tag_of(int b);
        case (b)
            24: return "R5";
            23: return "R3";
            22: return "R4";
            21: return "R6";
            20: return "R7";
            12: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check_pass();
        vectors++;
        if (out_valid !== in_valid || out_data !== in_data || out_first !== in_first ||
            out_last !== in_last || out_bytes !== in_bytes || in_ready !== out_ready) begin
            miscompares++;
            $display("FAIL R1 passthrough: got v%0b d%h f%0b l%0b b%0d r%0b exp v%0b d%h f%0b l%0b b%0d r%0b",
                     out_valid, out_data, out_first, out_last, out_bytes, in_ready,
                     in_valid, in_data, in_first, in_last, in_bytes, out_ready);
        end
    endtask

    // one clock: drive, check passthrough, predict, clock, compare causes
    task automatic beat(input bit v, input bit r, input bit f, input bit l, input bit e,
                        input bit bad_par, input int nbytes, input longint meta,
                        input logic [DATA_W-1:0] d);
        logic [31:0] exp;
        bit fire, was_open;
        longint old;
        in_valid = v; out_ready = r; in_first = f; in_last = l; in_err = e;
        in_data = d; in_par = (^d) ^ bad_par;
        in_bytes = BYTES_W'(nbytes); in_meta_len = CNT_W'(meta);
        #1;
        check_pass();
        exp = '0;
        fire = v && r;
        if (fire) begin
            was_open = m_open;
            if (e) exp[21] = 1;
            if ((^d) ^ in_par) exp[20] = 1;
            if (f) begin
                if (was_open) exp[22] = 1;
                m_cnt = nbytes;
            end else begin
                old = m_cnt;
                m_cnt = m_cnt + nbytes;
                if (m_cnt > CMAX) m_cnt = CMAX;
                if (m_cnt == CMAX && old != CMAX) exp[12] = 1;
            end
            if (l) begin
                if (f || was_open) begin
                    if (m_cnt != meta) exp[24] = 1;
                end else exp[23] = 1;
                m_open = 0;
            end else if (f) m_open = 1;
        end
        @(posedge clk); #1;
        vectors++;
        if (err_cause !== exp) begin
            miscompares++;
            for (int b = 0; b < 32; b++)
                if (err_cause[b] !== exp[b])
                    $display("FAIL %s cause bit %0d: got %h exp %h",
                             fire ? tag_of(b) : "R9", b, err_cause, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog expired: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (err_cause !== 32'h0) begin
            miscompares++;
            $display("FAIL R2 reset: got %h exp 0", err_cause);
        end
        check_pass();
        rst_n = 1;
        @(posedge clk); #1;

        // R5 clean three-beat packet, correct length
        beat(1,1,1,0,0,0,  8, 0,   32'h1234_5678);
        beat(1,1,0,0,0,0, 16, 0,   32'hdead_beef);
        beat(1,1,0,1,0,0,  4, 28,  32'h0f0f_0001);
        // R5 single-beat packet, wrong length
        beat(1,1,1,1,0,0, 10, 11,  32'haaaa_5555);
        // R5 single-beat packet, right length
        beat(1,1,1,1,0,0, 10, 10,  32'h0000_0003);
        // R3 stray last, no length check even with mismatching meta
        beat(1,1,0,1,0,0,  5, 99,  32'h1);
        // R4 first inside an open packet restarts count
        beat(1,1,1,0,0,0, 20, 0,   32'h2);
        beat(1,1,0,0,0,0, 20, 0,   32'h3);
        beat(1,1,1,0,0,0,  7, 0,   32'h4);
        beat(1,1,0,1,0,0,  3, 10,  32'h5);
        // R6 error flag, R7 parity errors
        beat(1,1,1,0,1,0,  4, 0,   32'h6);
        beat(1,1,0,0,0,1,  4, 0,   32'hffff_0000);
        beat(1,1,0,1,1,1,  4, 12,  32'h7);
        // R9 stalls carrying bad content change nothing
        beat(1,0,1,1,1,1,  9, 1,   32'h8);
        beat(0,1,0,1,1,1,  9, 1,   32'h9);
        beat(0,0,1,0,1,1, 50, 0,   32'ha);
        beat(1,1,0,1,0,0,  2, 5,   32'hb);
        beat(1,1,1,0,0,0,  6, 0,   32'hc);
        beat(1,0,1,0,0,0,  6, 0,   32'hd);
        beat(0,1,0,0,0,0, 60, 0,   32'he);
        beat(1,1,0,1,0,0,  6, 12,  32'hf);
        // R8 exact hit of all ones, then stays saturated
        beat(1,1,1,0,0,0, 95, 0,   32'h10);
        for (int i = 0; i < 16; i++) beat(1,1,0,0,0,0, 250, 0, 32'(i));
        beat(1,1,0,0,0,0, 10, 0,   32'h11);
        beat(1,1,0,1,0,0,  1, CMAX, 32'h12);
        // R8 unframed data overshoots without framing flags
        beat(1,1,1,1,0,0, 200, 200, 32'h13);
        for (int i = 0; i < 20; i++) beat(1,1,0,0,0,0, 255, 0, 32'(i + 100));
        beat(1,1,1,1,0,0, 1, 1,    32'h14);
        // R8 first after saturation reloads
        beat(1,1,1,0,0,0, 30, 0,   32'h15);
        beat(1,1,0,1,0,0, 30, 60,  32'h16);
        beat(0,0,0,0,0,0,  0, 0,   32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule